// File: doc/BRIEF.md
# Clock Divider Parameter Search Engine

This block searches for the multiplier and divider pair of a PLL that comes closest to a requested output frequency without reaching it. A single-cycle `start` pulse captures a target in kHz. The engine then tries every divider from 1 to 15, and for each divider every multiplier from 9 to 127. It does this once against a 3000 kHz reference and once against a 6000 kHz reference. It reports the winning pair, the frequency that pair produces, whether the doubled reference won, and whether any pair qualified at all.

One candidate is evaluated per clock. The candidate frequency is the truncated quotient of multiplier times reference over divider. The engine does not divide for each candidate. For each divider, a small restoring divider splits the reference into a whole step and a remainder step. An accumulator then walks the quotient upward one multiplier at a time.

The request side is a plain pulse, not a handshake. While `busy` is high, a new `start` is dropped rather than held back. The result side carries no back-pressure: `done` strobes for one cycle, and the result pins hold their values until the next accepted request completes.

Top module: `pll_pair_search`

## Requirements
- R1: A successful result always has `div_m` in 1..15 and `mul_n` in 9..127. The search visits dividers in increasing order in the outer loop and multipliers in increasing order in the inner loop.
- R2: `freq_khz` equals floor(`mul_n` × ref / `div_m`). Here ref is 6000 when `dbl_ref` is 1 and 3000 when it is 0.
- R3: A candidate is kept only when target − candidate is greater than zero and less than the best margin so far. The margin starts at 1,000,000 for each reference. On equal margins, the earlier candidate in scan order is kept.
- R4: The 6000 kHz result is reported (`dbl_ref`=1) only when its frequency is strictly greater than the 3000 kHz result, or when the 3000 kHz pass found nothing. Otherwise the 3000 kHz pair is reported.
- R5: When neither pass finds a candidate, `fail` is 1 and `div_m`, `div_field`, `mul_n`, `freq_khz` and `dbl_ref` are all 0.
- R6: On success, `div_field` equals `div_m` − 1.
- R7: A `start` pulse that arrives while `busy` is 1 is ignored. The running search completes with its original target.
- R8: `done` is high for exactly one cycle per accepted request. All result pins stay unchanged from then until the next `done`.
- R9: `done` arrives no more than 2 × 15 × (128 + 13 + 2) + 6 cycles after the accepted `start`.
- R10: After reset, `busy`, `done`, `fail`, `dbl_ref` and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; taken only when idle |
| target_khz | input | 21 | Requested frequency in kHz, captured with `start` |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion strobe |
| fail | output | 1 | No candidate qualified |
| dbl_ref | output | 1 | Result uses the 6000 kHz reference |
| div_m | output | 4 | Chosen divider (0 on failure) |
| div_field | output | 4 | Divider register field, `div_m` − 1 |
| mul_n | output | 7 | Chosen multiplier (0 on failure) |
| freq_khz | output | 21 | Frequency produced by the chosen pair |

## Verification
The bench builds the engine with its default parameters: dividers 1..15, multipliers 9..127, references 3000 and 6000 kHz, and a 21-bit target. At these values one full search costs only about 4300 cycles. That lets the bench run every one of the 3570 candidate evaluations for each of two dozen targets and compare against an arithmetic model of the same scan.

The chosen targets cover several boundaries:
- the smallest reachable frequency, and one kHz above it;
- values on either side of the largest single-reference and doubled-reference frequencies;
- values where the 1,000,000 kHz margin limit disqualifies one or both passes;
- targets where both references reach the same frequency, so the tie rule of R4 decides.

// File: rtl/pps_pkg.sv
`timescale 1ns/1ps
package pps_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_DIV  = 2'd1,
    S_SCAN = 2'd2,
    S_PASS = 2'd3
  } pps_state_t;
endpackage

// File: rtl/pps_ref_divider.sv
`timescale 1ns/1ps
// Restoring divider: splits the reference by the current divider, one bit per cycle.
module pps_ref_divider #(
  parameter int DW = 13,
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          valid,
  output logic [DW-1:0] quo,
  output logic [VW-1:0] rem
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] shreg;
  logic [VW-1:0] part;
  logic [VW-1:0] dsr;
  logic [CW-1:0] cnt;
  logic          run;
  logic [VW:0]   trial;
  logic          ge;
  logic [VW:0]   nxt;

  always_comb begin
    trial = {part, shreg[DW-1]};
    ge    = trial >= {1'b0, dsr};
    nxt   = ge ? (trial - {1'b0, dsr}) : trial;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      part  <= '0;
      dsr   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        shreg <= dividend;
        dsr   <= divisor;
        part  <= '0;
        cnt   <= CW'(DW);
        run   <= 1'b1;
      end else if (run) begin
        shreg <= {shreg[DW-2:0], ge};
        part  <= nxt[VW-1:0];
        cnt   <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run   <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  assign quo = shreg;
  assign rem = part;

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  p_rem_below_divisor_r2: assert property (@(posedge clk) disable iff (rst)
    (valid && dsr != '0) |-> (part < dsr));
endmodule

// File: rtl/pps_quot_stepper.sv
`timescale 1ns/1ps
// Walks floor(n*ref/m) upward as n increments, using quotient and remainder steps.
module pps_quot_stepper #(
  parameter int FW = 21,
  parameter int DW = 13,
  parameter int VW = 4,
  parameter int NW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          step,
  input  logic [DW-1:0] q_step,
  input  logic [VW-1:0] r_step,
  input  logic [VW-1:0] m,
  output logic [FW-1:0] q,
  output logic [VW-1:0] r,
  output logic [NW-1:0] n
);
  logic [VW:0] rsum;
  logic        wrap;
  logic [VW:0] rnext;

  always_comb begin
    rsum  = {1'b0, r} + {1'b0, r_step};
    wrap  = rsum >= {1'b0, m};
    rnext = wrap ? (rsum - {1'b0, m}) : rsum;
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      q <= '0;
      r <= '0;
      n <= '0;
    end else if (step) begin
      q <= q + FW'(q_step) + FW'(wrap);
      r <= rnext[VW-1:0];
      n <= n + 1'b1;
    end
  end

  p_rem_stays_below_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !init) |=> (r < $past(m)));
  p_quot_monotone_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !init) |=> (q >= $past(q)));
endmodule

// File: rtl/pps_best_keeper.sv
`timescale 1ns/1ps
// Holds the best candidate below the target for one reference pass.
module pps_best_keeper #(
  parameter int FW   = 21,
  parameter int MW   = 4,
  parameter int NW   = 7,
  parameter int INIT = 1000000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          eval,
  input  logic [FW-1:0] target,
  input  logic [FW-1:0] cand_q,
  input  logic [MW-1:0] cand_m,
  input  logic [NW-1:0] cand_n,
  output logic          found,
  output logic [MW-1:0] best_m,
  output logic [NW-1:0] best_n,
  output logic [FW-1:0] best_f
);
  logic [FW-1:0] best_gap;
  logic          below;
  logic [FW-1:0] gap;
  logic          take;

  always_comb begin
    below = target > cand_q;
    gap   = target - cand_q;
    take  = eval && below && (gap < best_gap);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      best_gap <= FW'(INIT);
      found    <= 1'b0;
      best_m   <= '0;
      best_n   <= '0;
      best_f   <= '0;
    end else if (take) begin
      best_gap <= gap;
      found    <= 1'b1;
      best_m   <= cand_m;
      best_n   <= cand_n;
      best_f   <= cand_q;
    end
  end

  p_gap_shrinks_r3: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (best_gap <= $past(best_gap)));
  p_kept_below_target_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && take) |=> (found && best_f < $past(target)));
endmodule

// File: rtl/pll_pair_search.sv
`timescale 1ns/1ps
module pll_pair_search #(
  parameter int M_MIN     = 1,
  parameter int M_MAX     = 15,
  parameter int N_MIN     = 9,
  parameter int N_MAX     = 127,
  parameter int REF_LO    = 3000,
  parameter int REF_HI    = 6000,
  parameter int F_W       = 21,
  parameter int BEST_INIT = 1000000,
  localparam int M_W      = $clog2(M_MAX + 1),
  localparam int N_W      = $clog2(N_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [F_W-1:0] target_khz,
  output logic           busy,
  output logic           done,
  output logic           fail,
  output logic           dbl_ref,
  output logic [M_W-1:0] div_m,
  output logic [M_W-1:0] div_field,
  output logic [N_W-1:0] mul_n,
  output logic [F_W-1:0] freq_khz
);
  import pps_pkg::*;

  localparam int R_W = $clog2(REF_HI + 1);

  pps_state_t     state;
  logic           hi_pass;
  logic [M_W-1:0] m_cur;
  logic [F_W-1:0] target_q;

  logic           lo_found;
  logic [M_W-1:0] lo_m;
  logic [N_W-1:0] lo_n;
  logic [F_W-1:0] lo_f;

  logic           accept, last_n, scan_end, more_m, pass_flip;
  logic           div_go, st_init, st_step, kp_eval, kp_clr, hi_take;
  logic [M_W-1:0] div_m_in;
  logic [R_W-1:0] div_ref_in;

  logic           dv_valid;
  logic [R_W-1:0] dv_quo;
  logic [M_W-1:0] dv_rem;
  logic [F_W-1:0] st_q;
  logic [M_W-1:0] st_r;
  logic [N_W-1:0] st_n;
  logic           kp_found;
  logic [M_W-1:0] kp_m;
  logic [N_W-1:0] kp_n;
  logic [F_W-1:0] kp_f;

  always_comb begin
    accept     = (state == S_IDLE) && start;
    last_n     = st_n == N_W'(N_MAX);
    scan_end   = (state == S_SCAN) && last_n;
    more_m     = m_cur != M_W'(M_MAX);
    pass_flip  = (state == S_PASS) && !hi_pass;
    div_go     = accept || (scan_end && more_m) || pass_flip;
    div_m_in   = (scan_end && more_m) ? (m_cur + 1'b1) : M_W'(M_MIN);
    if (accept)         div_ref_in = R_W'(REF_LO);
    else if (pass_flip) div_ref_in = R_W'(REF_HI);
    else                div_ref_in = hi_pass ? R_W'(REF_HI) : R_W'(REF_LO);
    st_init    = (state == S_DIV) && dv_valid;
    st_step    = (state == S_SCAN) && !last_n;
    kp_eval    = (state == S_SCAN) && (st_n >= N_W'(N_MIN));
    kp_clr     = accept || pass_flip;
    hi_take    = kp_found && (!lo_found || (kp_f > lo_f));
  end

  assign busy = state != S_IDLE;

  pps_ref_divider #(.DW(R_W), .VW(M_W)) u_div (
    .clk(clk), .rst(rst), .go(div_go),
    .dividend(div_ref_in), .divisor(div_m_in),
    .valid(dv_valid), .quo(dv_quo), .rem(dv_rem)
  );

  pps_quot_stepper #(.FW(F_W), .DW(R_W), .VW(M_W), .NW(N_W)) u_step (
    .clk(clk), .rst(rst), .init(st_init), .step(st_step),
    .q_step(dv_quo), .r_step(dv_rem), .m(m_cur),
    .q(st_q), .r(st_r), .n(st_n)
  );

  pps_best_keeper #(.FW(F_W), .MW(M_W), .NW(N_W), .INIT(BEST_INIT)) u_keep (
    .clk(clk), .rst(rst), .clr(kp_clr), .eval(kp_eval),
    .target(target_q), .cand_q(st_q), .cand_m(m_cur), .cand_n(st_n),
    .found(kp_found), .best_m(kp_m), .best_n(kp_n), .best_f(kp_f)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      hi_pass   <= 1'b0;
      m_cur     <= '0;
      target_q  <= '0;
      lo_found  <= 1'b0;
      lo_m      <= '0;
      lo_n      <= '0;
      lo_f      <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      dbl_ref   <= 1'b0;
      div_m     <= '0;
      div_field <= '0;
      mul_n     <= '0;
      freq_khz  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          target_q <= target_khz;
          hi_pass  <= 1'b0;
          m_cur    <= div_m_in;
          state    <= S_DIV;
        end
        S_DIV: if (dv_valid) state <= S_SCAN;
        S_SCAN: if (last_n) begin
          if (more_m) begin
            m_cur <= div_m_in;
            state <= S_DIV;
          end else begin
            state <= S_PASS;
          end
        end
        S_PASS: begin
          if (!hi_pass) begin
            lo_found <= kp_found;
            lo_m     <= kp_m;
            lo_n     <= kp_n;
            lo_f     <= kp_f;
            hi_pass  <= 1'b1;
            m_cur    <= div_m_in;
            state    <= S_DIV;
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
            if (hi_take) begin
              fail      <= 1'b0;
              dbl_ref   <= 1'b1;
              div_m     <= kp_m;
              div_field <= kp_m - 1'b1;
              mul_n     <= kp_n;
              freq_khz  <= kp_f;
            end else if (lo_found) begin
              fail      <= 1'b0;
              dbl_ref   <= 1'b0;
              div_m     <= lo_m;
              div_field <= lo_m - 1'b1;
              mul_n     <= lo_n;
              freq_khz  <= lo_f;
            end else begin
              fail      <= 1'b1;
              dbl_ref   <= 1'b0;
              div_m     <= '0;
              div_field <= '0;
              mul_n     <= '0;
              freq_khz  <= '0;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_results_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({fail, dbl_ref, div_m, div_field, mul_n, freq_khz}));
  p_range_r1: assert property (@(posedge clk) disable iff (rst)
    (done && !fail) |-> (div_m >= M_W'(M_MIN) && div_m <= M_W'(M_MAX) &&
                         mul_n >= N_W'(N_MIN) && mul_n <= N_W'(N_MAX)));
  p_fail_zeroed_r5: assert property (@(posedge clk) disable iff (rst)
    (done && fail) |-> (div_m == '0 && mul_n == '0 && freq_khz == '0 && !dbl_ref));
  p_target_held_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (target_q == $past(target_q)));
  p_below_target_r3: assert property (@(posedge clk) disable iff (rst)
    (done && !fail) |-> (freq_khz < target_q));
endmodule

// File: tb/tb_pll_pair_search.sv
`timescale 1ns/1ps
module tb_pll_pair_search;
  localparam int F_W   = 21;
  localparam int BOUND = 2 * 15 * (128 + 13 + 2) + 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [F_W-1:0] target_khz = '0;
  logic           busy, done, fail, dbl_ref;
  logic [3:0]     div_m, div_field;
  logic [6:0]     mul_n;
  logic [F_W-1:0] freq_khz;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pll_pair_search dut (
    .clk(clk), .rst(rst), .start(start), .target_khz(target_khz),
    .busy(busy), .done(done), .fail(fail), .dbl_ref(dbl_ref),
    .div_m(div_m), .div_field(div_field), .mul_n(mul_n), .freq_khz(freq_khz)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic scan_ref(input int t, input int rf, output int bm, output int bn, output int bf);
    int best = 1000000;
    bm = 0; bn = 0; bf = 0;
    for (int m = 1; m <= 15; m++) begin
      for (int n = 9; n <= 127; n++) begin
        int f = (n * rf) / m;
        int d = t - f;
        if (d > 0 && d < best) begin
          best = d; bm = m; bn = n; bf = f;
        end
      end
    end
  endtask

  task automatic model(input int t, output int em, output int en, output int ef,
                       output int edbl, output int efail);
    int m1, n1, f1, m2, n2, f2;
    scan_ref(t, 3000, m1, n1, f1);
    scan_ref(t, 6000, m2, n2, f2);
    edbl = 0; efail = 0;
    em = m1; en = n1; ef = f1;
    if (f2 > f1) begin
      edbl = 1; em = m2; en = n2; ef = f2;
    end
    if (em == 0) begin
      efail = 1; en = 0; ef = 0;
    end
  endtask

  task automatic run_one(input int t, input bit inject);
    int em, en, ef, edbl, efail, cyc;
    logic [3:0] hm; logic [6:0] hn; logic [F_W-1:0] hf; logic hd, hfl;
    model(t, em, en, ef, edbl, efail);
    @(negedge clk);
    start = 1'b1; target_khz = F_W'(t);
    @(negedge clk);
    start = 1'b0; target_khz = '0;
    cyc = 1;
    while (!done && cyc <= BOUND + 20) begin
      if (inject && cyc == 40) begin
        start = 1'b1; target_khz = F_W'(t ^ 21'h0F0F0);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(cyc <= BOUND, $sformatf("R9 latency t=%0d", t), cyc, BOUND);
    chk(fail == efail, $sformatf("R5 fail t=%0d", t), fail, efail);
    chk(int'(div_m) == em, $sformatf("R3 div_m t=%0d", t), div_m, em);
    chk(int'(mul_n) == en, $sformatf("R3 mul_n t=%0d", t), mul_n, en);
    chk(int'(dbl_ref) == edbl, $sformatf("R4 dbl_ref t=%0d", t), dbl_ref, edbl);
    chk(int'(freq_khz) == ef, $sformatf("R2 freq t=%0d", t), freq_khz, ef);
    if (efail == 0) begin
      int rf = dbl_ref ? 6000 : 3000;
      int dm = (div_m == 0) ? 1 : int'(div_m);
      chk(int'(freq_khz) == (int'(mul_n) * rf) / dm, $sformatf("R2 pair freq t=%0d", t),
          freq_khz, (int'(mul_n) * rf) / dm);
      chk(div_m >= 1 && div_m <= 15 && mul_n >= 9 && mul_n <= 127,
          $sformatf("R1 range t=%0d", t), div_m, mul_n);
      chk(int'(div_field) == em - 1, $sformatf("R6 field t=%0d", t), div_field, em - 1);
    end else begin
      chk(div_field == 0 && dbl_ref == 0, $sformatf("R5 zero field t=%0d", t), div_field, 0);
    end
    if (inject) chk(1'b1 == (int'(mul_n) == en), "R7 start ignored while busy", mul_n, en);
    hm = div_m; hn = mul_n; hf = freq_khz; hd = dbl_ref; hfl = fail;
    @(negedge clk);
    chk(done == 1'b0, $sformatf("R8 done pulse t=%0d", t), done, 0);
    repeat (3) @(negedge clk);
    chk(hm == div_m && hn == mul_n && hf == freq_khz && hd == dbl_ref && hfl == fail,
        $sformatf("R8 hold t=%0d", t), freq_khz, hf);
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int tlist[24] = '{0, 1800, 1801, 3001, 5000, 6001, 9001, 25175, 27000, 65000,
                      74250, 108000, 148500, 193250, 381000, 381001, 400000, 762000,
                      762001, 1100000, 1381000, 1381001, 2000000, 2097151};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && fail == 0 && dbl_ref == 0 && div_m == 0 &&
        div_field == 0 && mul_n == 0 && freq_khz == 0, "R10 reset state", freq_khz, 0);
    foreach (tlist[i]) run_one(tlist[i], 1'b0);
    run_one(74250, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule